// File: doc/BRIEF.md
# Privileged control register bank

This block holds the 64-bit control and status registers that privileged code in a small CPU core reads and writes by register index. It offers one read port and one write port. Each index has its own write rule: kept whole, kept through a field mask, cleared by any write, refused, or accepted but not readable. An access that the rule forbids, or an index that selects no register, raises a fault flag in the same cycle as the access. Read data and read fault are combinational. A write takes effect at the next rising clock edge.

One register holds a cycle count. Its upper half is stored state. Its lower half is always the low 32 bits of a free-running cycle counter, taken at the moment of the read. While the core is executing down a speculative path it asserts `spec`. Writes in that state are dropped quietly. A read of the faulting-address register normally releases an interrupt lock, but it does not do so during speculation.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every readable register reads as zero, `irq_lock` is 0 and the cycle counter restarts from zero.
- R2: Scratch indices 0x00 to NUM_SCRATCH-1 and the faulting-address register at 0x13 store all 64 written bits. The value reads back from the cycle after the write, with `rd_fault` low.
- R3: The cycle register at 0x08 stores a full write. A read returns the stored bits [63:32] above the low 32 bits of a counter that starts at 0 on the first clock edge after reset and then adds one on every clock edge.
- R4: Field masks applied on write: 0x0A and 0x0B keep bits [3:0], 0x0C keeps bits [4:0], 0x0D keeps value AND 0x18, and 0x0E keeps value AND 0x7FFF0.
- R5: The exception-address register at 0x12 stores the written value with bit 1 forced to zero.
- R6: Any write to 0x10 or 0x11 clears that register to zero. The write reports no fault.
- R7: Writes to the read-only indices 0x20, 0x21 and 0x22 raise `wr_fault` and leave the register unchanged. Reads of these indices do not fault.
- R8: Reads of the write-only indices 0x28 to 0x2B return zero and raise `rd_fault`. Writes to them report no fault.
- R9: An index that selects no register, for example 0x07 or 0x3F, raises `rd_fault` with zero data on a read and `wr_fault` on a write.
- R10: While `spec` is high a write changes no register and `wr_fault` stays low, whatever the index.
- R11: `lock_set` sets `irq_lock` at the next edge. A non-speculative read of 0x13 clears it at the next edge. If both happen in the same cycle, the set wins.
- R12: The first write to the counter-control register at 0x09 makes it read 1. Any later write while it holds 1 raises `wr_fault` and the register keeps the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spec | input | 1 | Current access is speculative |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | 64 | Read data, combinational |
| rd_fault | output | 1 | Illegal read, combinational |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write register index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Illegal write, combinational |
| lock_set | input | 1 | Raise the interrupt lock |
| irq_lock | output | 1 | Interrupt lock state |

## Verification
The bench builds the bank with its defaults: a 6-bit index, four scratch registers and a 64-bit counter. A 6-bit index covers every decoded register. It also covers both the gap below the cycle register and the top index 0x3F, so decode holes can be probed from the ports. Four scratch slots put the writable scratch range right next to the gap at 0x07, which checks the boundary between the two. The 64-bit counter stays well below wrap during the run, so the bench can track the expected low half with its own edge count.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   localparam int XLEN      = 64;
   localparam int SLOT_W    = 5;
   localparam int NUM_FIXED = 14;

   localparam logic [7:0] IX_CYC   = 8'h08;
   localparam logic [7:0] IX_CCTL  = 8'h09;
   localparam logic [7:0] IX_ASTR  = 8'h0A;
   localparam logic [7:0] IX_ASTE  = 8'h0B;
   localparam logic [7:0] IX_IPL   = 8'h0C;
   localparam logic [7:0] IX_MODE  = 8'h0D;
   localparam logic [7:0] IX_SWI   = 8'h0E;
   localparam logic [7:0] IX_ESUM  = 8'h10;
   localparam logic [7:0] IX_EMSK  = 8'h11;
   localparam logic [7:0] IX_EADDR = 8'h12;
   localparam logic [7:0] IX_VA    = 8'h13;
   localparam logic [7:0] IX_INTID = 8'h20;
   localparam logic [7:0] IX_MMST  = 8'h21;
   localparam logic [7:0] IX_SRCV  = 8'h22;
   localparam logic [7:0] IX_WO_LO = 8'h28;
   localparam logic [7:0] IX_WO_HI = 8'h2B;

   // slot offsets after the scratch slots
   localparam int OF_CYC   = 0;
   localparam int OF_CCTL  = 1;
   localparam int OF_ASTR  = 2;
   localparam int OF_EADDR = 9;

   typedef enum logic [2:0] {
      RK_NONE, RK_MASK, RK_CLR, RK_RO, RK_WO, RK_CCTL, RK_CYC
   } rkind_e;

   typedef struct packed {
      rkind_e            kind;
      logic [SLOT_W-1:0] slot;
      logic [XLEN-1:0]   mask;   // implemented bits
   } rdec_t;

   function automatic rdec_t mk(input rkind_e k, input int s, input logic [XLEN-1:0] m);
      rdec_t d;
      d.kind = k;
      d.slot = SLOT_W'(s);
      d.mask = m;
      return d;
   endfunction

   function automatic rdec_t reg_decode(input logic [7:0] idx, input int ns);
      rdec_t d = mk(RK_NONE, 0, '0);
      if (int'(idx) < ns) begin
         d = mk(RK_MASK, int'(idx), '1);
      end else begin
         case (idx)
            IX_CYC:   d = mk(RK_CYC,  ns + OF_CYC,  '1);
            IX_CCTL:  d = mk(RK_CCTL, ns + OF_CCTL, 64'h1);
            IX_ASTR:  d = mk(RK_MASK, ns + OF_ASTR, 64'hF);
            IX_ASTE:  d = mk(RK_MASK, ns + 3,  64'hF);
            IX_IPL:   d = mk(RK_MASK, ns + 4,  64'h1F);
            IX_MODE:  d = mk(RK_MASK, ns + 5,  64'h18);
            IX_SWI:   d = mk(RK_MASK, ns + 6,  64'h7FFF0);
            IX_ESUM:  d = mk(RK_CLR,  ns + 7,  '1);
            IX_EMSK:  d = mk(RK_CLR,  ns + 8,  '1);
            IX_EADDR: d = mk(RK_MASK, ns + OF_EADDR, ~64'h2);
            IX_VA:    d = mk(RK_MASK, ns + 10, '1);
            IX_INTID: d = mk(RK_RO,   ns + 11, '1);
            IX_MMST:  d = mk(RK_RO,   ns + 12, '1);
            IX_SRCV:  d = mk(RK_RO,   ns + 13, '1);
            default: begin
               if (idx >= IX_WO_LO && idx <= IX_WO_HI) d = mk(RK_WO, 0, '0);
            end
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
   import ctlreg_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int NUM_SCRATCH = 4
) (
   input  logic [IDX_W-1:0] idx,
   output rdec_t            dec
);
   assign dec = reg_decode(8'(idx), NUM_SCRATCH);
endmodule

// File: rtl/ctlreg_cycctr.sv
module ctlreg_cycctr #(
   parameter int CNT_W = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] cnt_lo
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (CNT_W == 32) begin : g_exact
         assign cnt_lo = cnt_q;
      end else begin : g_wide
         assign cnt_lo = cnt_q[31:0];
      end
   endgenerate
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int NUM_SCRATCH = 4,
   parameter int CNT_W       = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spec,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [63:0]      rd_data,
   output logic             rd_fault,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [63:0]      wr_data,
   output logic             wr_fault,
   input  logic             lock_set,
   output logic             irq_lock
);
   localparam int NSLOT    = NUM_SCRATCH + NUM_FIXED;
   localparam int SLOT_N   = 1 << SLOT_W;
   localparam int SL_CCTL  = NUM_SCRATCH + OF_CCTL;
   localparam int SL_ASTR  = NUM_SCRATCH + OF_ASTR;
   localparam int SL_EADDR = NUM_SCRATCH + OF_EADDR;

   generate
      if (IDX_W < 6 || IDX_W > 8) begin : g_bad_idx
         $error("ctlreg_bank: IDX_W must lie in 6..8");
      end
      if (NUM_SCRATCH < 1 || NUM_SCRATCH > 8) begin : g_bad_ns
         $error("ctlreg_bank: NUM_SCRATCH must lie in 1..8");
      end
      if (CNT_W < 32 || CNT_W > 64) begin : g_bad_cnt
         $error("ctlreg_bank: CNT_W must lie in 32..64");
      end
   endgenerate

   rdec_t rdec, wdec;
   logic [31:0] cyc_lo;
   logic [63:0] slot_q [SLOT_N];
   logic        wr_live, wr_commit, cctl_set, va_rd, lock_q;
   logic [63:0] wr_next, rd_raw;
   logic [63:0] eaddr_q, astr_q;

   ctlreg_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH)) u_rdec (.idx(rd_idx), .dec(rdec));
   ctlreg_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH)) u_wdec (.idx(wr_idx), .dec(wdec));
   ctlreg_cycctr #(.CNT_W(CNT_W)) u_cyc (.clk(clk), .rst_n(rst_n), .cnt_lo(cyc_lo));

   // write side
   assign wr_live  = wr_en && !spec;
   assign cctl_set = slot_q[SL_CCTL][0];

   always_comb begin
      wr_fault = 1'b0;
      if (wr_live) begin
         if (wdec.kind inside {RK_NONE, RK_RO}) wr_fault = 1'b1;
         else if (wdec.kind == RK_CCTL && cctl_set) wr_fault = 1'b1;
      end
   end

   always_comb begin
      case (wdec.kind)
         RK_MASK, RK_CYC: wr_next = wr_data & wdec.mask;
         RK_CCTL:         wr_next = 64'd1;
         default:         wr_next = '0;
      endcase
   end

   assign wr_commit = wr_live && !wr_fault &&
                      (wdec.kind inside {RK_MASK, RK_CYC, RK_CLR, RK_CCTL});

   generate
      for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
         if (g < NSLOT) begin : g_reg
            logic [63:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= '0;
               else if (wr_commit && wdec.slot == SLOT_W'(g)) q <= wr_next;
            end
            assign slot_q[g] = q;
         end else begin : g_pad
            assign slot_q[g] = '0;
         end
      end
   endgenerate

   // read side
   assign rd_fault = rd_en && (rdec.kind inside {RK_NONE, RK_WO});
   assign rd_raw   = slot_q[rdec.slot] & rdec.mask;

   always_comb begin
      rd_data = '0;
      if (rd_en && !rd_fault) begin
         if (rdec.kind == RK_CYC) rd_data = {rd_raw[63:32], cyc_lo};
         else                     rd_data = rd_raw;
      end
   end

   // interrupt lock
   assign va_rd = rd_en && !spec && (rd_idx == IDX_W'(IX_VA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (lock_set) lock_q <= 1'b1;
      else if (va_rd)    lock_q <= 1'b0;
   end
   assign irq_lock = lock_q;

   // observation points for the bound checker
   assign eaddr_q = slot_q[SL_EADDR];
   assign astr_q  = slot_q[SL_ASTR];
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
   import ctlreg_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spec,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_idx,
   input logic [63:0]      rd_data,
   input logic             rd_fault,
   input logic             wr_en,
   input logic             wr_fault,
   input logic             lock_set,
   input logic             irq_lock,
   input logic [31:0]      cyc_lo,
   input logic [63:0]      eaddr_q,
   input logic [63:0]      astr_q
);
   p_spec_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && spec) |-> !wr_fault);

   p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fault |-> (rd_data == 64'd0));

   p_eaddr_bit1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |-> !eaddr_q[1]);

   p_ast_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |-> (astr_q[63:4] == 60'd0));

   p_cyc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cyc_lo == $past(cyc_lo) + 32'd1));

   p_lock_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_set |=> irq_lock);

   p_lock_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !spec && !lock_set && rd_idx == IDX_W'(IX_VA)) |=> !irq_lock);
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spec(spec), .rd_en(rd_en), .rd_idx(rd_idx),
   .rd_data(rd_data), .rd_fault(rd_fault), .wr_en(wr_en), .wr_fault(wr_fault),
   .lock_set(lock_set), .irq_lock(irq_lock), .cyc_lo(cyc_lo),
   .eaddr_q(eaddr_q), .astr_q(astr_q)
);

// File: tb/sim_ctlreg_bank.sv
module sim_ctlreg_bank;
   localparam int IDX_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             spec = 1'b0, rd_en = 1'b0, wr_en = 1'b0, lock_set = 1'b0;
   logic [IDX_W-1:0] rd_idx = '0, wr_idx = '0;
   logic [63:0]      wr_data = '0;
   logic [63:0]      rd_data;
   logic             rd_fault, wr_fault, irq_lock;

   int n_run = 0, n_fail = 0;
   logic [31:0] bcyc = '0;

   typedef struct {
      logic [63:0] d;
      logic        rf;
      logic        wf;
      string       tag;
   } exp_t;
   exp_t sb[$];

   ctlreg_bank #(.IDX_W(IDX_W), .NUM_SCRATCH(4), .CNT_W(64)) u0 (
      .clk(clk), .rst_n(rst_n), .spec(spec), .rd_en(rd_en), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_fault(rd_fault), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_fault(wr_fault), .lock_set(lock_set), .irq_lock(irq_lock)
   );

   always #2 clk = ~clk;   // 250 MHz

   // independent model of the cycle counter (R3)
   always @(posedge clk) begin
      if (!rst_n) bcyc <= '0;
      else        bcyc <= bcyc + 32'd1;
   end

   // driver: one access per cycle, expected outcome pushed to the scoreboard
   task automatic acc(input bit re, input logic [IDX_W-1:0] ri, input bit we,
                      input logic [IDX_W-1:0] wi, input logic [63:0] wd, input bit sp,
                      input logic [63:0] ed, input bit cyc, input bit erf, input bit ewf,
                      input string tag);
      exp_t e;
      @(negedge clk);
      rd_en = re; rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd;
      spec = sp; lock_set = 1'b0;
      e.d   = cyc ? {ed[63:32], bcyc} : ed;
      e.rf  = erf;
      e.wf  = ewf;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic rd(input logic [IDX_W-1:0] ri, input logic [63:0] ed, input bit erf,
                     input string tag);
      acc(1'b1, ri, 1'b0, '0, '0, 1'b0, ed, 1'b0, erf, 1'b0, tag);
   endtask

   task automatic wr(input logic [IDX_W-1:0] wi, input logic [63:0] wd, input bit ewf,
                     input string tag);
      acc(1'b0, '0, 1'b1, wi, wd, 1'b0, 64'd0, 1'b0, 1'b0, ewf, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; spec = 1'b0; lock_set = 1'b0;
   endtask

   task automatic lchk(input logic exp, input string tag);
      idle();
      #1;
      n_run++;
      if (irq_lock !== exp) begin
         n_fail++;
         $display("FAIL %s irq_lock actual=%b expected=%b", tag, irq_lock, exp);
      end
   endtask

   // monitor: compare the ports against the oldest expected item
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (rd_data !== e.d || rd_fault !== e.rf || wr_fault !== e.wf) begin
               n_fail++;
               $display("FAIL %s actual data=%h rf=%b wf=%b expected data=%h rf=%b wf=%b",
                        e.tag, rd_data, rd_fault, wr_fault, e.d, e.rf, e.wf);
            end
         end
      end
   end

   initial begin
      #(4 * 50000);
      n_fail++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(6'h00, 64'd0, 1'b0, "R1 scratch0");
      rd(6'h0C, 64'd0, 1'b0, "R1 ipl");
      acc(1'b1, 6'h08, 1'b0, '0, '0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, "R1 cycle");
      lchk(1'b0, "R1 lock");

      // R2: full writes
      wr(6'h01, 64'hA5A5_5A5A_0123_4567, 1'b0, "R2 wr s1");
      rd(6'h01, 64'hA5A5_5A5A_0123_4567, 1'b0, "R2 rd s1");
      wr(6'h03, 64'hFFFF_0000_FFFF_0000, 1'b0, "R2 wr s3");
      rd(6'h03, 64'hFFFF_0000_FFFF_0000, 1'b0, "R2 rd s3");
      wr(6'h13, 64'h0000_0000_DEAD_0000, 1'b0, "R2 wr va");
      rd(6'h13, 64'h0000_0000_DEAD_0000, 1'b0, "R2 rd va");

      // R4: field masks
      wr(6'h0A, '1, 1'b0, "R4 wr astr");
      rd(6'h0A, 64'hF, 1'b0, "R4 astr");
      wr(6'h0B, 64'h35, 1'b0, "R4 wr aste");
      rd(6'h0B, 64'h5, 1'b0, "R4 aste");
      wr(6'h0C, 64'hFF, 1'b0, "R4 wr ipl");
      rd(6'h0C, 64'h1F, 1'b0, "R4 ipl");
      wr(6'h0D, 64'h3C, 1'b0, "R4 wr mode");
      rd(6'h0D, 64'h18, 1'b0, "R4 mode");
      wr(6'h0E, '1, 1'b0, "R4 wr swi");
      rd(6'h0E, 64'h7FFF0, 1'b0, "R4 swi");

      // R5: exception address bit 1
      wr(6'h12, '1, 1'b0, "R5 wr eaddr");
      rd(6'h12, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, "R5 eaddr");

      // R6: clear on write
      wr(6'h10, '1, 1'b0, "R6 wr esum");
      rd(6'h10, 64'd0, 1'b0, "R6 esum");
      wr(6'h11, 64'h1234, 1'b0, "R6 wr emsk");
      rd(6'h11, 64'd0, 1'b0, "R6 emsk");

      // R7: read-only
      wr(6'h20, 64'h1234, 1'b1, "R7 wr intid");
      rd(6'h20, 64'd0, 1'b0, "R7 rd intid");
      wr(6'h22, '1, 1'b1, "R7 wr srcv");
      rd(6'h22, 64'd0, 1'b0, "R7 rd srcv");

      // R8: write-only
      rd(6'h28, 64'd0, 1'b1, "R8 rd 28");
      wr(6'h29, 64'h77, 1'b0, "R8 wr 29");
      rd(6'h2B, 64'd0, 1'b1, "R8 rd 2b");

      // R9: undecoded
      rd(6'h3F, 64'd0, 1'b1, "R9 rd 3f");
      wr(6'h3F, 64'h1, 1'b1, "R9 wr 3f");
      rd(6'h07, 64'd0, 1'b1, "R9 rd 07");

      // R10: speculative writes
      acc(1'b0, '0, 1'b1, 6'h01, 64'd0, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, "R10 spec wr s1");
      rd(6'h01, 64'hA5A5_5A5A_0123_4567, 1'b0, "R10 s1 kept");
      acc(1'b0, '0, 1'b1, 6'h3F, 64'd1, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, "R10 spec wr 3f");
      acc(1'b0, '0, 1'b1, 6'h20, 64'd1, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, "R10 spec wr ro");

      // R11: interrupt lock
      idle();
      @(negedge clk);
      lock_set = 1'b1;
      lchk(1'b1, "R11 set");
      acc(1'b1, 6'h13, 1'b0, '0, '0, 1'b1, 64'h0000_0000_DEAD_0000, 1'b0, 1'b0, 1'b0,
          "R11 spec va rd");
      lchk(1'b1, "R11 spec keeps lock");
      rd(6'h13, 64'h0000_0000_DEAD_0000, 1'b0, "R11 va rd");
      lchk(1'b0, "R11 cleared");
      @(negedge clk);
      lock_set = 1'b1; rd_en = 1'b1; rd_idx = 6'h13;
      lchk(1'b1, "R11 set wins");

      // R12: counter control
      rd(6'h09, 64'd0, 1'b0, "R12 cctl init");
      wr(6'h09, 64'h55, 1'b0, "R12 first wr");
      rd(6'h09, 64'd1, 1'b0, "R12 cctl one");
      wr(6'h09, 64'h0, 1'b1, "R12 second wr");
      rd(6'h09, 64'd1, 1'b0, "R12 cctl kept");

      // R3: cycle register merge
      wr(6'h08, 64'h1234_5678_9ABC_DEF0, 1'b0, "R3 wr cyc");
      acc(1'b1, 6'h08, 1'b0, '0, '0, 1'b0, 64'h1234_5678_0000_0000, 1'b1, 1'b0, 1'b0,
          "R3 cyc rd");
      repeat (5) idle();
      acc(1'b1, 6'h08, 1'b0, '0, '0, 1'b0, 64'h1234_5678_0000_0000, 1'b1, 1'b0, 1'b0,
          "R3 cyc later");

      repeat (3) idle();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule